// File: doc/BRIEF.md
# Byte-Wide EEPROM Host Access and Burst Loader

This block sits between a host register bus and an external byte-wide EEPROM. The host uses it in two ways.

For a single access, the host loads an EEPROM address register and a data register. It then sets a read-request bit or a write-request bit in a control register. The block runs one byte transfer on the EEPROM port, and the request bit drops by itself when the transfer is over.

For a burst load, the host sets a start bit. The block then walks the EEPROM byte by byte and turns the records it finds into 32-bit writes to a 24-bit internal memory space.

Each burst record is six bytes long:
- two address bytes, low byte first;
- four data bytes, low byte first.

The memory address is built from a 9-bit base register, which gives the upper bits, and the low 15 bits of the record address. Bit 15 of the record address is discarded. A record address of 0xFFFF ends the burst.

A burst begins at EEPROM address 0 if no access has completed since reset. Otherwise it begins just after the last byte that completed. If the EEPROM fails to acknowledge within the timeout, the transfer is abandoned, an error flag is raised and the request bits clear.

Top module: `eep_host_loader`

Host register index (reg_addr):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | CTRL | bit 0 write request, bit 1 read request |
| 1 | EADDR | 16-bit EEPROM address |
| 2 | EDATA | 8-bit EEPROM data |
| 3 | BURST | bit 0 start |
| 4 | BASE | 9-bit upper memory address |
| 5 | STATUS | bit 0 busy, bit 1 error |

Top controller states and transitions:
- TOP_IDLE goes to TOP_SINGLE when a single request is accepted, and to TOP_BURST when a burst start is accepted.
- TOP_SINGLE returns to TOP_IDLE on acknowledge or timeout.
- TOP_BURST returns to TOP_IDLE on the terminator or on a timeout.

Byte transfer states:
- BX_IDLE goes to BX_WAIT on start.
- BX_WAIT returns to BX_IDLE on acknowledge or when the timeout count expires.

Burst sequencer states:
- BS_IDLE goes to BS_ISSUE on go.
- BS_ISSUE goes to BS_WAIT.
- From BS_WAIT, a received byte leads to BS_ISSUE for the next byte, or to BS_WRITE after the sixth byte, or to BS_IDLE on the terminator. A timeout also leads to BS_IDLE.
- BS_WRITE goes back to BS_ISSUE.

## Requirements
- R1: Writing CTRL with bit 1 set while idle reads the EEPROM byte at EADDR into EDATA. CTRL bit 1 then returns to 0 by itself once the byte has arrived.
- R2: EDATA holds 8 bits. Reads of EDATA return 0 in bits above bit 7, and its content after a read is valid once CTRL bit 1 is 0.
- R3: Writing CTRL with bit 0 set (and bit 1 clear) while idle writes EDATA[7:0] to EEPROM address EADDR, and bit 0 clears by itself on completion. If both bits are written as 1, only the read is performed.
- R4: Writing BURST with bit 0 set while idle starts a burst. BURST bit 0 reads 1 until the burst ends, and memory writes happen only while it is 1.
- R5: A burst starts at EEPROM address 0 if no access has completed since reset. Otherwise it starts at one past the address of the last completed byte access, single or burst.
- R6: Each burst record of 6 bytes (address little-endian, then data little-endian) produces exactly one memory write. The write carries the 4 data bytes as a 32-bit word, to address {BASE[8:0], record address[14:0]}, and bit 15 of the record address is ignored.
- R7: A record address of 0xFFFF ends the burst, with no memory write and without fetching data bytes.
- R8: If the EEPROM does not acknowledge within TIMEOUT_CYC (10000) cycles of a request, the access is abandoned and the request bits clear. STATUS bit 1 becomes 1 and stays set until the next accepted request clears it.
- R9: A CTRL or BURST request written while the block is busy is ignored. STATUS bit 0 reads 1 while a single access or burst is in progress.
- R10: On the EEPROM port, ee_req is held with stable ee_addr, ee_we and ee_wdata until ee_ack, and drops in the cycle after ee_ack.
- R11: After reset all registers read 0, and ee_req and mem_we are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register index |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | EEPROM request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | 24 | Internal memory address |
| mem_wdata | output | 32 | Internal memory write data |

## Verification
Bursts are run from three different start points: address 0 right after reset, the byte after a single write, and the byte after an earlier burst. A wrong resume pointer therefore shows up as wrong memory addresses in the scoreboard. The records use record addresses with and without bit 15 set, and two different base values, which separates correct address formation from a simple copy of the 16-bit field. Single reads, single writes and a request with both bits set tell read priority apart from a write slipping through. A request written during a burst, and a request the EEPROM never acknowledges, cover the ignore rule, the timeout and the error recovery.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // host register indices
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_EADDR  = 3'd1;
    localparam logic [2:0] IDX_EDATA  = 3'd2;
    localparam logic [2:0] IDX_BURST  = 3'd3;
    localparam logic [2:0] IDX_BASE   = 3'd4;
    localparam logic [2:0] IDX_STATUS = 3'd5;

    typedef enum logic [1:0] {
        TOP_IDLE,
        TOP_SINGLE,
        TOP_BURST
    } top_state_t;

    typedef enum logic {
        BX_IDLE,
        BX_WAIT
    } bx_state_t;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_ISSUE,
        BS_WAIT,
        BS_WRITE
    } bs_state_t;

endpackage

// File: rtl/eep_byte_xfer.sv
module eep_byte_xfer
    import eep_pkg::*;
#(
    parameter int AW          = 16,
    parameter int TIMEOUT_CYC = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_wdata,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          ee_req,
    output logic          ee_we,
    output logic [AW-1:0] ee_addr,
    output logic [7:0]    ee_wdata,
    input  logic          ee_ack
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_CYC - 1);

    bx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    wdata_q;
    logic          expire;

    assign expire = (cnt == LAST_CNT);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            BX_IDLE: if (start) nxt = BX_WAIT;
            BX_WAIT: if (ee_ack || expire) nxt = BX_IDLE;
            default: nxt = BX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BX_IDLE;
        else        state <= nxt;
    end

    // request latch and timeout counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state == BX_IDLE) begin
            cnt <= '0;
            if (start) begin
                we_q    <= start_we;
                addr_q  <= start_addr;
                wdata_q <= start_wdata;
            end
        end else if (!ee_ack && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (state == BX_WAIT);
        done     = busy && ee_ack;
        timeout  = busy && !ee_ack && expire;
        ee_req   = busy;
        ee_we    = busy && we_q;
        ee_addr  = addr_q;
        ee_wdata = wdata_q;
    end

endmodule

// File: rtl/eep_burst_seq.sv
module eep_burst_seq
    import eep_pkg::*;
#(
    parameter int AW     = 16,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     go_addr,
    input  logic [BASE_W-1:0] base,
    input  logic              x_done,
    input  logic              x_timeout,
    input  logic [7:0]        x_byte,
    output logic              x_start,
    output logic [AW-1:0]     x_addr,
    output logic              fin,
    output logic              fault,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);

    localparam int LOW_W      = MEM_AW - BASE_W;
    localparam int ADDR_BYTES = AW / 8;
    localparam int DATA_BYTES = DW / 8;
    localparam int REC_BYTES  = ADDR_BYTES + DATA_BYTES;
    localparam int IW         = $clog2(REC_BYTES);
    localparam logic [IW-1:0] IDX_ALAST = IW'(ADDR_BYTES - 1);
    localparam logic [IW-1:0] IDX_RLAST = IW'(REC_BYTES - 1);

    bs_state_t     state, nxt;
    logic [IW-1:0] idx;
    logic [AW-1:0] cur;
    logic [7:0]    rec_q [REC_BYTES];
    logic [AW-1:0] field_now;
    logic [AW-1:0] field_q;
    logic          is_end;
    logic          last_addr_byte;

    // record address as it stands once the incoming byte is included
    always_comb begin
        for (int i = 0; i < ADDR_BYTES; i++) begin
            field_now[i*8 +: 8] = (IW'(i) == idx) ? x_byte : rec_q[i];
            field_q[i*8 +: 8]   = rec_q[i];
        end
        for (int j = 0; j < DATA_BYTES; j++) begin
            mem_wdata[j*8 +: 8] = rec_q[ADDR_BYTES + j];
        end
    end

    assign last_addr_byte = (idx == IDX_ALAST);
    assign is_end         = last_addr_byte && (&field_now);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            BS_IDLE:  if (go) nxt = BS_ISSUE;
            BS_ISSUE: nxt = BS_WAIT;
            BS_WAIT: begin
                if (x_done) begin
                    if (is_end)                nxt = BS_IDLE;
                    else if (idx == IDX_RLAST) nxt = BS_WRITE;
                    else                       nxt = BS_ISSUE;
                end else if (x_timeout) begin
                    nxt = BS_IDLE;
                end
            end
            BS_WRITE: nxt = BS_ISSUE;
            default:  nxt = BS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BS_IDLE;
        else        state <= nxt;
    end

    // byte index, address pointer and record bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
            cur <= '0;
            for (int k = 0; k < REC_BYTES; k++) rec_q[k] <= '0;
        end else begin
            unique case (state)
                BS_IDLE: begin
                    if (go) begin
                        cur <= go_addr;
                        idx <= '0;
                    end
                end
                BS_WAIT: begin
                    if (x_done) begin
                        rec_q[idx] <= x_byte;
                        cur        <= cur + 1'b1;
                        if (idx != IDX_RLAST) idx <= idx + 1'b1;
                    end
                end
                BS_WRITE: idx <= '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        x_start  = (state == BS_ISSUE);
        x_addr   = cur;
        fin      = (state == BS_WAIT) && x_done && is_end;
        fault    = (state == BS_WAIT) && x_timeout;
        mem_we   = (state == BS_WRITE);
        mem_addr = {base, field_q[LOW_W-1:0]};
    end

endmodule

// File: rtl/eep_host_loader.sv
module eep_host_loader
    import eep_pkg::*;
#(
    parameter int EE_AW       = 16,
    parameter int MEM_AW      = 24,
    parameter int BASE_W      = 9,
    parameter int DW          = 32,
    parameter int TIMEOUT_CYC = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [EE_AW-1:0]  reg_wdata,
    output logic [EE_AW-1:0]  reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic [7:0]        ee_rdata,
    input  logic              ee_ack,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);

    localparam int RW = EE_AW;

    top_state_t        state, nxt;
    logic              rd_req_q, wr_req_q, burst_q, err_q;
    logic [EE_AW-1:0]  addr_q, ptr_q;
    logic [7:0]        data_q;
    logic [BASE_W-1:0] base_q;

    logic wr_ctrl, wr_burst, accept_single, accept_burst, single_rd;
    logic              x_start, x_we, x_busy, x_done, x_timeout;
    logic [EE_AW-1:0]  x_addr;
    logic              b_x_start, b_fin, b_fault;
    logic [EE_AW-1:0]  b_x_addr;

    assign wr_ctrl       = reg_wr && (reg_addr == IDX_CTRL);
    assign wr_burst      = reg_wr && (reg_addr == IDX_BURST);
    assign single_rd     = reg_wdata[1];
    assign accept_single = (state == TOP_IDLE) && wr_ctrl && (reg_wdata[1] || reg_wdata[0]);
    assign accept_burst  = (state == TOP_IDLE) && wr_burst && reg_wdata[0];

    // one byte engine, shared by single accesses and the burst sequencer
    assign x_start = accept_single || b_x_start;
    assign x_we    = accept_single && !single_rd;
    assign x_addr  = accept_single ? addr_q : b_x_addr;

    eep_byte_xfer #(
        .AW          (EE_AW),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (x_start),
        .start_we    (x_we),
        .start_addr  (x_addr),
        .start_wdata (data_q),
        .busy        (x_busy),
        .done        (x_done),
        .timeout     (x_timeout),
        .ee_req      (ee_req),
        .ee_we       (ee_we),
        .ee_addr     (ee_addr),
        .ee_wdata    (ee_wdata),
        .ee_ack      (ee_ack)
    );

    eep_burst_seq #(
        .AW     (EE_AW),
        .MEM_AW (MEM_AW),
        .BASE_W (BASE_W),
        .DW     (DW)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept_burst),
        .go_addr   (ptr_q),
        .base      (base_q),
        .x_done    (x_done),
        .x_timeout (x_timeout),
        .x_byte    (ee_rdata),
        .x_start   (b_x_start),
        .x_addr    (b_x_addr),
        .fin       (b_fin),
        .fault     (b_fault),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            TOP_IDLE: begin
                if (accept_single)     nxt = TOP_SINGLE;
                else if (accept_burst) nxt = TOP_BURST;
            end
            TOP_SINGLE: if (x_done || x_timeout) nxt = TOP_IDLE;
            TOP_BURST:  if (b_fin || b_fault)    nxt = TOP_IDLE;
            default:    nxt = TOP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TOP_IDLE;
        else        state <= nxt;
    end

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            burst_q  <= 1'b0;
            err_q    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            base_q   <= '0;
            ptr_q    <= '0;
        end else begin
            if (reg_wr && reg_addr == IDX_EADDR) addr_q <= reg_wdata;
            if (reg_wr && reg_addr == IDX_EDATA) data_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == IDX_BASE)  base_q <= reg_wdata[BASE_W-1:0];

            // resume pointer follows every completed byte access
            if (x_done) ptr_q <= ee_addr + 1'b1;

            unique case (state)
                TOP_IDLE: begin
                    if (accept_single) begin
                        rd_req_q <= single_rd;
                        wr_req_q <= !single_rd;
                        err_q    <= 1'b0;
                    end else if (accept_burst) begin
                        burst_q <= 1'b1;
                        err_q   <= 1'b0;
                    end
                end
                TOP_SINGLE: begin
                    if (x_done) begin
                        if (rd_req_q) data_q <= ee_rdata;
                        rd_req_q <= 1'b0;
                        wr_req_q <= 1'b0;
                    end else if (x_timeout) begin
                        rd_req_q <= 1'b0;
                        wr_req_q <= 1'b0;
                        err_q    <= 1'b1;
                    end
                end
                TOP_BURST: begin
                    if (b_fin) begin
                        burst_q <= 1'b0;
                    end else if (b_fault) begin
                        burst_q <= 1'b0;
                        err_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // host read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            IDX_CTRL:   reg_rdata = RW'({rd_req_q, wr_req_q});
            IDX_EADDR:  reg_rdata = addr_q;
            IDX_EDATA:  reg_rdata = RW'(data_q);
            IDX_BURST:  reg_rdata = RW'(burst_q);
            IDX_BASE:   reg_rdata = RW'(base_q);
            IDX_STATUS: reg_rdata = RW'({err_q, (state != TOP_IDLE) || x_busy});
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eep_host_loader_chk.sv
module eep_host_loader_chk #(
    parameter int EE_AW  = 16,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_req,
    input logic              ee_ack,
    input logic              ee_we,
    input logic [EE_AW-1:0]  ee_addr,
    input logic [7:0]        ee_wdata,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              rd_req_q,
    input logic              wr_req_q,
    input logic              burst_q,
    input logic              err_q
);

    localparam int LOW_W = MEM_AW - BASE_W;

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && $past(ee_req)) |-> ($stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_ack) |=> !ee_req);

    assert_mem_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[MEM_AW-1:LOW_W] == base_q));

    assert_mem_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> burst_q);

    assert_one_activity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_q, wr_req_q, burst_q}));

    assert_req_needs_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> (rd_req_q || wr_req_q || burst_q));

    assert_read_selfclear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_req_q) |-> ($past(ee_ack) || err_q));

endmodule

bind eep_host_loader eep_host_loader_chk #(
    .EE_AW  (EE_AW),
    .MEM_AW (MEM_AW),
    .BASE_W (BASE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ee_req   (ee_req),
    .ee_ack   (ee_ack),
    .ee_we    (ee_we),
    .ee_addr  (ee_addr),
    .ee_wdata (ee_wdata),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_q   (base_q),
    .rd_req_q (rd_req_q),
    .wr_req_q (wr_req_q),
    .burst_q  (burst_q),
    .err_q    (err_q)
);

// File: tb/test_eep_host_loader.sv
module test_eep_host_loader;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic [7:0]  ee_rdata = '0;
    logic        ee_ack = 1'b0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int hs_viol = 0;
    bit ack_en  = 1'b1;
    int ack_lat = 3;
    bit finished = 1'b0;

    logic [7:0]  eemem [256];
    logic [55:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_host_loader i_eep_host_loader (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_rdata(ee_rdata), .ee_ack(ee_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input int cap);
        logic [15:0] s;
        for (int i = 0; i < cap; i++) begin
            reg_read(3'd5, s);
            if (!s[0]) break;
        end
    endtask

    // scoreboard driver side
    task automatic push_expect(input logic [23:0] a, input logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic put_record(input int at, input logic [15:0] ra, input logic [31:0] d);
        eemem[at]   = ra[7:0];   eemem[at+1] = ra[15:8];
        eemem[at+2] = d[7:0];    eemem[at+3] = d[15:8];
        eemem[at+4] = d[23:16];  eemem[at+5] = d[31:24];
    endtask

    task automatic put_end(input int at);
        eemem[at] = 8'hFF; eemem[at+1] = 8'hFF;
    endtask

    // scoreboard monitor side
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected memory write", {8'h0, mem_addr}, 32'h0);
                end else begin
                    logic [55:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e[55:32], "R6 memory address", {8'h0, mem_addr}, {8'h0, e[55:32]});
                    check(mem_wdata == e[31:0], "R6 memory data", mem_wdata, e[31:0]);
                end
            end
        end
    end

    // EEPROM model, driven away from the active edge
    initial begin
        int w;
        w = 0;
        forever begin
            @(negedge clk);
            if (ee_ack) begin
                ee_ack = 1'b0;
                if (ee_req) hs_viol++;   // R10 request must drop after ack
            end else if (ee_req && ack_en) begin
                w++;
                if (w >= ack_lat) begin
                    w = 0;
                    if (ee_we) eemem[ee_addr[7:0]] = ee_wdata;
                    ee_rdata = eemem[ee_addr[7:0]];
                    ee_ack = 1'b1;
                end
            end else begin
                w = 0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        for (int i = 0; i < 256; i++) eemem[i] = 8'h00;
        put_record(0,  16'h1234, 32'hA1B2C3D4);
        put_record(6,  16'h9ABC, 32'h12345678);
        put_end(12);
        eemem[8'h40] = 8'hC7;
        put_record(8'h51, 16'h0007, 32'h11223344);
        put_end(8'h57);
        put_record(8'h59, 16'h0100, 32'hCAFEF00D);
        put_end(8'h5F);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), r);
            check(r == 16'h0, "R11 register reset value", {16'h0, r}, 32'h0);
        end
        check(!ee_req && !mem_we, "R11 idle outputs", {30'h0, ee_req, mem_we}, 32'h0);

        // R5 first burst starts at 0; R6 records; R7 terminator
        reg_write(3'd4, 16'h01A5);
        push_expect({9'h1A5, 15'h1234}, 32'hA1B2C3D4);
        push_expect({9'h1A5, 15'h1ABC}, 32'h12345678);
        reg_write(3'd3, 16'h0001);
        reg_read(3'd3, r);
        check(r == 16'h1, "R4 burst bit set while running", {16'h0, r}, 32'h1);
        wait_idle(2000);
        reg_read(3'd3, r);
        check(r == 16'h0, "R4 burst bit clears at terminator", {16'h0, r}, 32'h0);
        check(exp_q.size() == 0, "R7 all records written before end", exp_q.size(), 32'h0);
        reg_read(3'd5, r);
        check(r == 16'h0, "R7 clean end without error", {16'h0, r}, 32'h0);

        // R1 single read
        reg_write(3'd1, 16'h0040);
        reg_write(3'd0, 16'h0002);
        wait_idle(2000);
        reg_read(3'd0, r);
        check(r == 16'h0, "R1 read bit self-clears", {16'h0, r}, 32'h0);
        reg_read(3'd2, r);
        check(r == 16'h00C7, "R1 read byte in data register", {16'h0, r}, 32'hC7);

        // R3 single write, R2 upper bits zero
        reg_write(3'd1, 16'h0050);
        reg_write(3'd2, 16'hFF5A);
        reg_read(3'd2, r);
        check(r == 16'h005A, "R2 data register upper bits read 0", {16'h0, r}, 32'h5A);
        reg_write(3'd0, 16'h0001);
        wait_idle(2000);
        reg_read(3'd0, r);
        check(r == 16'h0, "R3 write bit self-clears", {16'h0, r}, 32'h0);
        check(eemem[8'h50] == 8'h5A, "R3 byte written to EEPROM", {24'h0, eemem[8'h50]}, 32'h5A);
        reg_write(3'd2, 16'h0000);
        reg_write(3'd0, 16'h0002);
        wait_idle(2000);
        reg_read(3'd2, r);
        check(r == 16'h005A, "R2 read-back after read bit clears", {16'h0, r}, 32'h5A);

        // R5 burst resumes after last access (0x50 -> 0x51)
        reg_write(3'd4, 16'h0003);
        push_expect({9'h003, 15'h0007}, 32'h11223344);
        reg_write(3'd3, 16'h0001);
        wait_idle(2000);
        check(exp_q.size() == 0, "R5 burst resumed at next address", exp_q.size(), 32'h0);

        // R9 request during burst ignored; busy visible
        push_expect({9'h003, 15'h0100}, 32'hCAFEF00D);
        reg_write(3'd3, 16'h0001);
        reg_read(3'd5, r);
        check(r[0] == 1'b1, "R9 busy during burst", {16'h0, r}, 32'h1);
        reg_write(3'd0, 16'h0002);
        reg_write(3'd3, 16'h0001);
        wait_idle(2000);
        reg_read(3'd0, r);
        check(r == 16'h0, "R9 request during burst ignored", {16'h0, r}, 32'h0);
        reg_read(3'd2, r);
        check(r == 16'h005A, "R9 data untouched by ignored request", {16'h0, r}, 32'h5A);
        check(exp_q.size() == 0, "R9 burst completed once", exp_q.size(), 32'h0);

        // R3 both bits set: read only
        reg_write(3'd1, 16'h0040);
        reg_write(3'd2, 16'h0099);
        reg_write(3'd0, 16'h0003);
        reg_read(3'd0, r);
        check(r == 16'h0002, "R3 both bits keep only read", {16'h0, r}, 32'h2);
        wait_idle(2000);
        reg_read(3'd2, r);
        check(r == 16'h00C7, "R3 both bits performs read", {16'h0, r}, 32'hC7);
        check(eemem[8'h40] == 8'hC7, "R3 both bits writes nothing", {24'h0, eemem[8'h40]}, 32'hC7);

        // R8 timeout
        ack_en = 1'b0;
        reg_write(3'd0, 16'h0002);
        repeat (9000) @(negedge clk);
        reg_read(3'd0, r);
        check(r == 16'h0002, "R8 request still pending before timeout", {16'h0, r}, 32'h2);
        wait_idle(3000);
        reg_read(3'd0, r);
        check(r == 16'h0, "R8 request bits clear on timeout", {16'h0, r}, 32'h0);
        reg_read(3'd5, r);
        check(r == 16'h0002, "R8 error set, not busy", {16'h0, r}, 32'h2);
        ack_en = 1'b1;
        reg_write(3'd0, 16'h0002);
        wait_idle(2000);
        reg_read(3'd5, r);
        check(r == 16'h0, "R8 error cleared by next request", {16'h0, r}, 32'h0);

        check(hs_viol == 0, "R10 request dropped after ack", hs_viol, 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule